// File: doc/BRIEF.md
# Five-Pin Bidirectional Port with Direction Control

This block is a five-pin general-purpose I/O port that sits on an 8-bit register bus of a small controller. Each pin has an output latch bit and a direction bit. A direction bit of 1 makes the pin an input with its driver off. A direction bit of 0 drives the latch value onto the pin. Pins 0 to 3 use push-pull drive. Pin 4 is open-drain: it can only pull low. Its synchronized input level also leaves the block as a clock source for a timer.

Software chooses one of two registers with a select line. A read of the data register returns the synchronized pin levels, not the latch. A read of the direction register returns the direction bits. A full write replaces a whole register. A single-bit set or clear reads the synchronized pins, changes the addressed bit, and stores all five bits into the output latch. This matches the read-modify-write behaviour that software for such ports expects.

Top module: `bidir_port`

## Requirements
- R1: While reset is asserted and right after it, all five direction bits are 1, the output latch is 0, and every driveEn bit is 0.
- R2: A write with regSel=1 loads wrData[4:0] into the direction bits on the next clock edge. A read with regSel=1 returns {3'b000, direction}, so written bits 7:5 are dropped.
- R3: For pins 0 to 3, driveEn[i] is the inverse of direction bit i, and driveVal[i] equals latch bit i.
- R4: A write with regSel=0 loads wrData[4:0] into the output latch even while the pins are inputs. The stored value appears on driveVal, and is driven once the direction bits are cleared.
- R5: A read with regSel=0 returns {3'b000, pins} through a two-flop synchronizer. A pin level present before clock edge k appears on rdData after edge k+1, and not after edge k.
- R6: bitSetEn (or bitClrEn) with bitIdx below 5 loads the latch with the synchronized pin levels, with bit bitIdx forced to 1 (or 0). A bitIdx of 5 to 7 leaves the latch unchanged.
- R7: Priority is fixed: wrEn outranks both bit operations, and bitSetEn outranks bitClrEn when both are asserted in the same cycle.
- R8: Pin 4 is open-drain. driveVal[4] is always 0, and driveEn[4] is 1 exactly when direction bit 4 is 0 and latch bit 4 is 0.
- R9: timerClk equals synchronized pin 4 and has the same two-edge latency as R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register select: 0 data, 1 direction |
| wrEn | input | 1 | Full register write strobe |
| wrData | input | 8 | Write data bus |
| bitSetEn | input | 1 | Single-bit set strobe (read-modify-write) |
| bitClrEn | input | 1 | Single-bit clear strobe (read-modify-write) |
| bitIdx | input | 3 | Bit index for set and clear |
| rdData | output | 8 | Read data for the selected register |
| pinIn | input | 5 | Levels seen at the pins |
| driveEn | output | 5 | Per-pin output-driver enable |
| driveVal | output | 5 | Per-pin value to drive |
| timerClk | output | 1 | Synchronized pin 4 level for a timer |

## Verification
A wrong direction bit or latch bit shows on driveEn or driveVal one cycle after the write that caused it. It shows at once through a direction readback. A fault in the synchronizer shows up as rdData or timerClk changing one edge too early or too late after a pin change. A wrong bit operation puts a wrong value into the latch, and this can be hidden while the pin is an input, because driveVal still reflects the latch. That is why the bench compares driveVal on every clock against a behavioural model, and does not wait until the pin is switched to output.

// File: rtl/bidir_port_pkg.sv
package bidir_port_pkg;
  localparam int IDX_W = 3;

  typedef struct packed {
    logic             wrData;
    logic             wrDir;
    logic             bitOp;
    logic             bitVal;
    logic [IDX_W-1:0] bitSel;
  } portStrobe_t;
endpackage

// File: rtl/bidir_port_ctrl.sv
module bidir_port_ctrl
  import bidir_port_pkg::*;
#(
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             wrEn,
  input  logic             bitSetEn,
  input  logic             bitClrEn,
  input  logic [IDX_W-1:0] bitIdx,
  output portStrobe_t      strb
);
  logic idxInRange;
  assign idxInRange = (bitIdx < IDX_W'(PIN_W));

  always_comb begin
    strb = '0;
    if (wrEn) begin
      strb.wrData = ~regSel;
      strb.wrDir  = regSel;
    end else if ((bitSetEn || bitClrEn) && idxInRange) begin
      strb.bitOp  = 1'b1;
      strb.bitVal = bitSetEn;
      strb.bitSel = bitIdx;
    end
  end

  // At most one action per cycle reaches the datapath (R7)
  assert_one_action_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrData, strb.wrDir, strb.bitOp}));

  // An out-of-range index never produces a bit operation (R6)
  assert_oob_idx_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bitIdx >= IDX_W'(PIN_W)) |-> !strb.bitOp);
endmodule

// File: rtl/bidir_port_dp.sv
module bidir_port_dp
  import bidir_port_pkg::*;
#(
  parameter int PIN_W  = 5,
  parameter int BUS_W  = 8,
  parameter int OD_BIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strb,
  input  logic             regSel,
  input  logic [BUS_W-1:0] wrVal,
  input  logic [PIN_W-1:0] pinIn,
  output logic [BUS_W-1:0] rdData,
  output logic [PIN_W-1:0] driveEn,
  output logic [PIN_W-1:0] driveVal,
  output logic             timerClk
);
  localparam int PAD_W = BUS_W - PIN_W;

  logic [PIN_W-1:0] metaPins, syncPins;
  logic [PIN_W-1:0] latchQ, dirQ, modPins;

  // Two-flop input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaPins <= '0;
      syncPins <= '0;
    end else begin
      metaPins <= pinIn;
      syncPins <= metaPins;
    end
  end

  // Read-modify-write source: synchronized pins with one bit replaced
  for (genvar i = 0; i < PIN_W; i++) begin : gMod
    assign modPins[i] = (strb.bitSel == IDX_W'(i)) ? strb.bitVal : syncPins[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '1;
    end else begin
      if (strb.wrData)     latchQ <= wrVal[PIN_W-1:0];
      else if (strb.bitOp) latchQ <= modPins;
      if (strb.wrDir)      dirQ   <= wrVal[PIN_W-1:0];
    end
  end

  // Per-pin drivers: push-pull or open-drain
  for (genvar i = 0; i < PIN_W; i++) begin : gDrv
    if (i == OD_BIT) begin : gOpenDrain
      assign driveEn[i]  = ~dirQ[i] & ~latchQ[i];
      assign driveVal[i] = 1'b0;
    end else begin : gPushPull
      assign driveEn[i]  = ~dirQ[i];
      assign driveVal[i] = latchQ[i];
    end
  end

  assign rdData   = regSel ? {{PAD_W{1'b0}}, dirQ} : {{PAD_W{1'b0}}, syncPins};
  assign timerClk = syncPins[OD_BIT];

  // Cycles since reset, saturating, for history-based checks
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> dirQ == $past(wrVal[PIN_W-1:0]));

  assert_latch_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> latchQ == $past(wrVal[PIN_W-1:0]));

  assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> syncPins == $past(pinIn, 2));

  assert_bit_op_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitOp |=> latchQ[$past(strb.bitSel)] == $past(strb.bitVal));

  assert_od_pull_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bitOp && !strb.bitVal && strb.bitSel == IDX_W'(OD_BIT) && !dirQ[OD_BIT]
      && !strb.wrDir) |=> driveEn[OD_BIT]);
endmodule

// File: rtl/bidir_port.sv
module bidir_port
  import bidir_port_pkg::*;
#(
  parameter int PIN_W  = 5,
  parameter int BUS_W  = 8,
  parameter int OD_BIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             wrEn,
  input  logic [BUS_W-1:0] wrData,
  input  logic             bitSetEn,
  input  logic             bitClrEn,
  input  logic [IDX_W-1:0] bitIdx,
  output logic [BUS_W-1:0] rdData,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] driveEn,
  output logic [PIN_W-1:0] driveVal,
  output logic             timerClk
);
  portStrobe_t strb;

  bidir_port_ctrl #(.PIN_W(PIN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn),
    .bitSetEn(bitSetEn), .bitClrEn(bitClrEn), .bitIdx(bitIdx), .strb(strb)
  );

  bidir_port_dp #(.PIN_W(PIN_W), .BUS_W(BUS_W), .OD_BIT(OD_BIT)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .regSel(regSel), .wrVal(wrData),
    .pinIn(pinIn), .rdData(rdData), .driveEn(driveEn), .driveVal(driveVal),
    .timerClk(timerClk)
  );

  // Open-drain pin never drives high (R8)
  assert_od_low_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveEn[OD_BIT]) |-> !driveVal[OD_BIT]);
endmodule

// File: tb/bidir_port_test.sv
module bidir_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regSel = 1'b0, wrEn = 1'b0, bitSetEn = 1'b0, bitClrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] bitIdx = '0;
  logic [4:0] pinIn = '0;
  logic [7:0] rdData;
  logic [4:0] driveEn, driveVal;
  logic       timerClk;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  bidir_port uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .bitSetEn(bitSetEn), .bitClrEn(bitClrEn), .bitIdx(bitIdx), .rdData(rdData),
    .pinIn(pinIn), .driveEn(driveEn), .driveVal(driveVal), .timerClk(timerClk)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [4:0] mDir = 5'h1F;
  logic [4:0] mLatch = 5'h00;
  logic [4:0] pinQ[$] = '{5'h00, 5'h00};

  always @(posedge clk) begin
    if (!rstN) begin
      mDir = 5'h1F; mLatch = 5'h00;
      pinQ = '{5'h00, 5'h00};
    end else begin
      logic [4:0] seen;
      seen = pinQ[0];
      if (wrEn) begin
        if (regSel) mDir = wrData[4:0];
        else        mLatch = wrData[4:0];
      end else if (bitSetEn && bitIdx < 5) begin
        mLatch = seen | (5'h01 << bitIdx);
      end else if (bitClrEn && bitIdx < 5) begin
        mLatch = seen & ~(5'h01 << bitIdx);
      end
      pinQ.push_back(pinIn);
      void'(pinQ.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R3/R8 driveEn", {3'b0, driveEn},
          {3'b0, ~mDir[4] & ~mLatch[4], ~mDir[3:0]});
      chk("R3/R8 driveVal", {3'b0, driveVal}, {3'b0, 1'b0, mLatch[3:0]});
      chk(regSel ? "R2 rdData" : "R5 rdData", rdData,
          regSel ? {3'b0, mDir} : {3'b0, pinQ[0]});
      chk("R9 timerClk", {7'b0, timerClk}, {7'b0, pinQ[0][4]});
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic regWrite(logic sel, logic [7:0] val);
    regSel = sel; wrData = val; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic bitOp(logic setOp, logic [2:0] idx);
    bitIdx = idx; bitSetEn = setOp; bitClrEn = ~setOp;
    tick();
    bitSetEn = 1'b0; bitClrEn = 1'b0;
  endtask

  task automatic readReg(logic sel, output logic [7:0] val);
    regSel = sel; #1; val = rdData;
  endtask

  initial begin
    logic [7:0] rv;
    tick(3);
    // R1: reset state
    chk("R1 driveEn in reset", {3'b0, driveEn}, 8'h00);
    rstN = 1'b1;
    tick();
    readReg(1'b1, rv);
    chk("R1 direction after reset", rv, 8'h1F);
    chk("R1 driveEn after reset", {3'b0, driveEn}, 8'h00);

    // R4: latch written while pins are inputs, then driven
    regWrite(1'b0, 8'h0A);
    chk("R4 no drive while input", {3'b0, driveEn}, 8'h00);
    chk("R4 latch on driveVal", {3'b0, driveVal}, 8'h0A);
    regWrite(1'b1, 8'h00);
    chk("R4 drive after dir clear", {3'b0, driveEn}, 8'h1F);
    chk("R4 driveVal after dir clear", {3'b0, driveVal}, 8'h0A);

    // R2: direction readback, upper bits dropped
    regWrite(1'b1, 8'hE3);
    readReg(1'b1, rv);
    chk("R2 direction readback", rv, 8'h03);
    chk("R3 driveEn from direction", {3'b0, driveEn}, 8'h1C);

    // R5, R9: synchronizer latency
    pinIn = 5'h15;
    tick(3);
    readReg(1'b0, rv);
    chk("R5 pin readback", rv, 8'h15);
    pinIn = 5'h0B;
    tick();
    chk("R5 one edge too early", rdData, 8'h15);
    chk("R9 timer one edge too early", {7'b0, timerClk}, 8'h01);
    tick();
    chk("R5 after two edges", rdData, 8'h0B);
    chk("R9 timer after two edges", {7'b0, timerClk}, 8'h00);

    // R6: bit set built from pins
    bitOp(1'b1, 3'd2);
    chk("R6 bit set uses pins", {3'b0, driveVal}, 8'h0F);
    chk("R8 od pulls low", {3'b0, driveEn}, 8'h1C);
    pinIn = 5'h1F;
    tick(3);
    bitOp(1'b0, 3'd0);
    chk("R6 bit clear uses pins", {3'b0, driveVal}, 8'h0E);
    chk("R8 od released on latch 1", {3'b0, driveEn}, 8'h0C);
    bitOp(1'b1, 3'd6);
    chk("R6 out-of-range index ignored", {3'b0, driveVal}, 8'h0E);
    bitOp(1'b0, 3'd5);
    chk("R6 index 5 ignored", {3'b0, driveVal}, 8'h0E);

    // R7: priority
    regSel = 1'b0; wrData = 8'h11; wrEn = 1'b1; bitIdx = 3'd1; bitSetEn = 1'b1;
    tick();
    wrEn = 1'b0; bitSetEn = 1'b0;
    chk("R7 write beats bit op", {3'b0, driveVal}, 8'h01);
    chk("R7 od released", {3'b0, driveEn}, 8'h0C);
    pinIn = 5'h00;
    tick(3);
    bitIdx = 3'd1; bitSetEn = 1'b1; bitClrEn = 1'b1;
    tick();
    bitSetEn = 1'b0; bitClrEn = 1'b0;
    chk("R7 set beats clear", {3'b0, driveVal}, 8'h02);
    chk("R8 od pulls after rmw", {3'b0, driveEn}, 8'h1C);

    // Mixed stimulus, compared against the model every clock
    for (int i = 0; i < 600; i++) begin
      pinIn    = 5'($urandom);
      regSel   = 1'($urandom);
      wrData   = 8'($urandom);
      wrEn     = ($urandom % 4) == 0;
      bitSetEn = ($urandom % 3) == 0;
      bitClrEn = ($urandom % 3) == 0;
      bitIdx   = 3'($urandom);
      tick();
    end
    wrEn = 1'b0; bitSetEn = 1'b0; bitClrEn = 1'b0;
    tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule